// File: doc/BRIEF.md
# Four-Phase Codeword Completion Detector

This block sits on the receiving end of a return-to-zero handshake link. The link carries a 10-bit unordered codeword on individual wires, with no separate request line. The wires are asynchronous to the local clock, so each passes through a synchronizer chain. Between transfers the link rests at the all-zero spacer. The sender then raises the 1 bits of one codeword, in any order and with any skew. The block decides when the word is complete, raises the acknowledge, and records the word for a downstream error decoder. When the sender returns the wires to the spacer, the block drops the acknowledge and re-arms for the next transfer.

In normal mode, completion means the synchronized pattern is a member of the weighted zero-sum code with even parity, and that it has stayed unchanged for a settle window. Because no codeword's 1 bits are a subset of another codeword's, a partially arrived word never passes this test. A time-out window, set by an input port, starts when the first 1 bit is seen. If the window expires before a codeword forms, the block captures the partial word, sets a sticky error flag and still acknowledges, so the handshake can finish. In bypass mode there is no timer: any nonzero pattern that holds still is acknowledged, whether or not it is a codeword.

The controller has four states:
- SPACER_WAIT, entered at reset, leaves for IDLE once the input has been zero and settled.
- IDLE goes to COLLECT on any nonzero input.
- COLLECT goes to ACK on ACCEPT (a settled codeword, or in bypass any settled nonzero word) or on EXPIRE (the window has run out). It goes back to IDLE on ABANDON (the input has settled back to zero).
- ACK goes to IDLE on RELEASE (the input has settled at zero).

Top module: `cw_completion_detector`

## Requirements
- R1: After reset, ack_out, timeout_err, word_good and word_out are all zero. A nonzero input that is present when reset ends is never acknowledged until the input has first returned to all-zero.
- R2: Codeword layout is as follows. Bit 0 is an even-parity bit over all 10 bits. Bits 5:1 are the check field. Data bits 6, 7, 8 and 9 carry weights 3, 5, 6 and 7. A word is valid when the check field equals the sum of the weights of the data bits that are 0 and the total count of 1s is even. In normal mode, with a window of 12 cycles, a valid word held steady is acknowledged within 8 cycles with word_good=1 and timeout_err=0. An invalid word is not acknowledged within 14 cycles.
- R3: Partially arrived codewords never raise ack_out. An input that changes every cycle is not acknowledged even in bypass mode. Acknowledge requires the input to be unchanged for the settle count.
- R4: In normal mode, a nonzero non-codeword held from the first 1 bit raises ack_out once the window (tmo_limit cycles after the block enters COLLECT) has expired. It also sets timeout_err=1, word_out=the partial word and word_good=0. With tmo_limit=12, ack_out is high 18 cycles after the word is driven.
- R5: timeout_err is sticky: a later clean transfer is acknowledged normally and leaves timeout_err at 1 until reset.
- R6: In bypass mode, every nonzero pattern held steady is acknowledged within 8 cycles. word_good shows whether the pattern is a codeword, and timeout_err stays 0.
- R7: ack_out stays high until the input has been all-zero for the settle count. It is still high 2 cycles after the spacer is driven and low 8 cycles after.
- R8: word_out and word_good keep their captured values for as long as ack_out is high, even if the input changes.
- R9: An all-zero input never raises ack_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | 1 = accept any settled nonzero pattern, timer off |
| tmo_limit | input | 16 | Time-out window in cycles after entering COLLECT |
| chan_in | input | 10 | Asynchronous codeword wires |
| ack_out | output | 1 | Acknowledge to the sender |
| word_out | output | 10 | Captured word |
| word_good | output | 1 | Captured word is a valid codeword |
| timeout_err | output | 1 | Sticky time-out flag |

## Verification
The hardest case to reach from the ports is a codeword that is still arriving. Every intermediate pattern is a strict subset of a valid word, and each must stay unacknowledged while the window keeps running. The bench builds all sixteen codewords and raises their bits one at a time, in ascending and then descending order, holding each partial pattern long enough to settle. It then checks that ack stays low until the last bit lands. Full sweeps of all 1023 nonzero patterns in both modes cover the accept-or-expire decision, and a fast-toggling input exercises the settle guard.

// File: rtl/cwcd_pkg.sv
package cwcd_pkg;

    typedef enum logic [1:0] {
        ST_SPACER_WAIT,
        ST_IDLE,
        ST_COLLECT,
        ST_ACK
    } cwcd_state_e;

    // idx-th positive integer (0-based) that is not a power of two: 3,5,6,7,9,...
    function automatic int nonpow_weight(input int idx);
        int seen;
        int res;
        seen = 0;
        res  = 0;
        for (int v = 3; v <= 2 * idx + 8; v++) begin
            if (((v & (v - 1)) != 0) && (res == 0)) begin
                if (seen == idx) res = v;
                seen++;
            end
        end
        return res;
    endfunction

    function automatic int weight_sum(input int dw);
        int s;
        s = 0;
        for (int j = 0; j < dw; j++) s += nonpow_weight(j);
        return s;
    endfunction

    function automatic int chk_width(input int dw);
        return $clog2(weight_sum(dw) + 1);
    endfunction

endpackage

// File: rtl/cwcd_sync.sv
module cwcd_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cwcd_settle.sv
module cwcd_settle #(
    parameter int W      = 10,
    parameter int SETTLE = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] word,
    output logic         settled
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    logic [W-1:0]     last;
    logic [CNT_W-1:0] cnt;
    logic             change;

    assign change = (word != last);

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= '0;
            cnt  <= '0;
        end else begin
            last <= word;
            if (change)
                cnt <= '0;
            else if (cnt < CNT_W'(SETTLE))
                cnt <= cnt + 1'b1;
        end
    end

    assign settled = !change && (cnt >= CNT_W'(SETTLE));

    AST_SETTLE_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(SETTLE)); // R3
endmodule

// File: rtl/cwcd_code_check.sv
module cwcd_code_check #(
    parameter int DATA_W = 4,
    parameter int CHK_W  = 5,
    parameter int CW_W   = 10
) (
    input  logic [CW_W-1:0] word,
    output logic            is_valid
);
    logic [CHK_W-1:0] zsum;

    always_comb begin
        zsum = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (!word[CHK_W + 1 + j])
                zsum = zsum + CHK_W'(cwcd_pkg::nonpow_weight(j));
        end
    end

    assign is_valid = (zsum == word[CHK_W:1]) && !(^word);
endmodule

// File: rtl/cwcd_timer.sv
module cwcd_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            tcnt <= '0;
        else if (tcnt != '1)
            tcnt <= tcnt + 1'b1;
    end

    assign expired = run && (tcnt >= limit);
endmodule

// File: rtl/cw_completion_detector.sv
module cw_completion_detector #(
    parameter int DATA_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE      = 2,
    parameter int TMR_W       = 16,
    localparam int CHK_W      = cwcd_pkg::chk_width(DATA_W),
    localparam int CW_W       = DATA_W + CHK_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass_en,
    input  logic [TMR_W-1:0] tmo_limit,
    input  logic [CW_W-1:0]  chan_in,
    output logic             ack_out,
    output logic [CW_W-1:0]  word_out,
    output logic             word_good,
    output logic             timeout_err
);
    import cwcd_pkg::*;

    cwcd_state_e     state, state_n;
    logic [CW_W-1:0] word_s;
    logic            settled, code_ok, expired, nonzero;
    logic            spacer_ok, accept, capture, set_err, tmr_run;

    cwcd_sync #(.W(CW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(chan_in), .q(word_s)
    );

    cwcd_settle #(.W(CW_W), .SETTLE(SETTLE)) u_settle (
        .clk(clk), .rst(rst), .word(word_s), .settled(settled)
    );

    cwcd_code_check #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_check (
        .word(word_s), .is_valid(code_ok)
    );

    assign tmr_run = (state == ST_COLLECT) && !bypass_en;

    cwcd_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .run(tmr_run), .limit(tmo_limit), .expired(expired)
    );

    assign nonzero   = |word_s;
    assign spacer_ok = settled && !nonzero;
    assign accept    = settled && nonzero && (bypass_en || code_ok);

    // next-state and transition strobes
    always_comb begin
        state_n = state;
        capture = 1'b0;
        set_err = 1'b0;
        unique case (state)
            ST_SPACER_WAIT: begin
                if (spacer_ok) state_n = ST_IDLE;
            end
            ST_IDLE: begin
                if (nonzero) state_n = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (spacer_ok) begin
                    state_n = ST_IDLE;                 // ABANDON
                end else if (accept) begin
                    state_n = ST_ACK;                  // ACCEPT
                    capture = 1'b1;
                end else if (!bypass_en && expired && nonzero) begin
                    state_n = ST_ACK;                  // EXPIRE
                    capture = 1'b1;
                    set_err = 1'b1;
                end
            end
            ST_ACK: begin
                if (spacer_ok) state_n = ST_IDLE;      // RELEASE
            end
            default: state_n = ST_SPACER_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_SPACER_WAIT;
        else     state <= state_n;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out    <= '0;
            word_good   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            if (capture) begin
                word_out  <= word_s;
                word_good <= code_ok;
            end
            if (set_err) timeout_err <= 1'b1;
        end
    end

    assign ack_out = (state == ST_ACK);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> timeout_err); // R5
    AST_NO_TMO_IN_BYPASS: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> !$past(bypass_en)); // R6
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_out && $past(ack_out)) |-> $stable(word_out)); // R8
    AST_RELEASE_ON_SPACER: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_out) |-> ($past(word_s) == '0)); // R7
    AST_ACK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_out) |-> (word_out != '0)); // R9
endmodule

// File: tb/cw_completion_detector_test.sv
module cw_completion_detector_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass_en = 1'b0;
    logic [15:0] tmo_limit = 16'd12;
    logic [9:0]  chan_in = '0;
    logic        ack_out, word_good, timeout_err;
    logic [9:0]  word_out;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cw_completion_detector uut (
        .clk(clk), .rst(rst), .bypass_en(bypass_en), .tmo_limit(tmo_limit),
        .chan_in(chan_in), .ack_out(ack_out), .word_out(word_out),
        .word_good(word_good), .timeout_err(timeout_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic bit ref_valid(input logic [9:0] w);
        int wt [4] = '{3, 5, 6, 7};
        int s = 0;
        for (int j = 0; j < 4; j++) if (!w[6+j]) s += wt[j];
        return (s == int'(w[5:1])) && ((^w) == 1'b0);
    endfunction

    function automatic logic [9:0] make_cw(input int d);
        int wt [4] = '{3, 5, 6, 7};
        int s = 0;
        logic [9:0] w;
        for (int j = 0; j < 4; j++) if (((d >> j) & 1) == 0) s += wt[j];
        w = {4'(d), 5'(s), 1'b0};
        w[0] = ^w;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [9:0] w);
        @(negedge clk);
        chan_in = w;
    endtask

    task automatic wait_e(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic [9:0] w);
        @(negedge clk);
        rst = 1'b1;
        chan_in = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait_e(6);
    endtask

    initial begin
        logic [9:0] cw;
        logic [9:0] part;
        logic [9:0] held;

        // R1 reset values
        do_reset('0);
        chk(ack_out == 0, "R1 ack", ack_out, 0);
        chk(word_out == 0, "R1 word", word_out, 0);
        chk(word_good == 0, "R1 good", word_good, 0);
        chk(timeout_err == 0, "R1 err", timeout_err, 0);

        // R1 nonzero present at reset exit waits for spacer
        cw = make_cw(5);
        do_reset(cw);
        wait_e(20);
        chk(ack_out == 0, "R1 no ack before spacer", ack_out, 0);
        put('0); wait_e(8);
        put(cw); wait_e(8);
        chk(ack_out == 1, "R1 ack after spacer", ack_out, 1);
        put('0); wait_e(8);

        // R9 zero never acks, both modes
        wait_e(30);
        chk(ack_out == 0, "R9 zero normal", ack_out, 0);
        bypass_en = 1'b1;
        wait_e(30);
        chk(ack_out == 0, "R9 zero bypass", ack_out, 0);
        bypass_en = 1'b0;

        // R2 / R4 / R7 normal-mode sweep over all nonzero patterns
        tmo_limit = 16'd12;
        for (int p = 1; p < 1024; p++) begin
            do_reset('0);
            put(10'(p));
            wait_e(8);
            if (ref_valid(10'(p))) begin
                chk(ack_out == 1, "R2 valid ack", ack_out, 1);
                chk(word_out == 10'(p), "R2 word", word_out, p);
                chk(word_good == 1, "R2 good", word_good, 1);
                chk(timeout_err == 0, "R2 no err", timeout_err, 0);
            end else begin
                chk(ack_out == 0, "R2 invalid no early ack", ack_out, 0);
                wait_e(6);
                chk(ack_out == 0, "R4 before window", ack_out, 0);
                wait_e(4);
                chk(ack_out == 1, "R4 ack after window", ack_out, 1);
                chk(timeout_err == 1, "R4 err", timeout_err, 1);
                chk(word_out == 10'(p), "R4 partial word", word_out, p);
                chk(word_good == 0, "R4 good", word_good, 0);
            end
            put('0);
            wait_e(2);
            chk(ack_out == 1, "R7 ack held", ack_out, 1);
            wait_e(6);
            chk(ack_out == 0, "R7 ack released", ack_out, 0);
        end

        // R5 sticky after timeout, then a clean transfer
        put(make_cw(9));
        wait_e(8);
        chk(ack_out == 1, "R5 clean ack", ack_out, 1);
        chk(timeout_err == 1, "R5 err sticky", timeout_err, 1);
        // R8 hold while ack high
        put(10'h3FF);
        wait_e(8);
        chk(ack_out == 1, "R8 ack stays", ack_out, 1);
        chk(word_out == make_cw(9), "R8 word held", word_out, make_cw(9));
        chk(word_good == 1, "R8 good held", word_good, 1);
        put('0); wait_e(8);

        // R3 bit-by-bit arrival, ascending and descending
        do_reset('0);
        tmo_limit = 16'd200;
        for (int d = 0; d < 16; d++) begin
            for (int dir = 0; dir < 2; dir++) begin
                cw = make_cw(d);
                part = '0;
                for (int k = 0; k < 10; k++) begin
                    int b;
                    b = (dir == 0) ? k : 9 - k;
                    if (cw[b]) begin
                        part[b] = 1'b1;
                        put(part);
                        wait_e(6);
                        if (part != cw)
                            chk(ack_out == 0, "R3 partial no ack", ack_out, 0);
                    end
                end
                wait_e(2);
                chk(ack_out == 1, "R3 complete ack", ack_out, 1);
                chk(word_out == cw, "R3 word", word_out, cw);
                chk(timeout_err == 0, "R3 no err", timeout_err, 0);
                put('0); wait_e(8);
            end
        end

        // R3 fast-changing input in bypass never settles
        bypass_en = 1'b1;
        held = '0;
        for (int i = 0; i < 20; i++) begin
            held = (i % 2) ? 10'h155 : 10'h2AA;
            put(held);
        end
        wait_e(1);
        chk(ack_out == 0, "R3 unsettled no ack", ack_out, 0);
        wait_e(8);
        chk(ack_out == 1, "R3 settled ack", ack_out, 1);
        chk(word_out == held, "R3 settled word", word_out, held);
        put('0); wait_e(8);

        // R6 bypass sweep
        for (int p = 1; p < 1024; p++) begin
            put(10'(p));
            wait_e(8);
            chk(ack_out == 1, "R6 ack", ack_out, 1);
            chk(word_out == 10'(p), "R6 word", word_out, p);
            chk(word_good == ref_valid(10'(p)), "R6 good", word_good, ref_valid(10'(p)));
            chk(timeout_err == 0, "R6 no err", timeout_err, 0);
            put('0);
            wait_e(8);
            chk(ack_out == 0, "R6 release", ack_out, 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule